// File: doc/BRIEF.md
# Indexed Chipset Configuration Register Port

This block holds a small bank of chipset configuration bytes behind two neighbouring byte-wide I/O addresses. The lower address is the selector: a write there latches the number of the register to reach, and a read there returns that number. The upper address is the data window: a write there updates the selected register, and a read there returns its contents. Each register number has a fixed write mask. Bits outside the mask are stored as zero. Register numbers with no defined mask keep their value when written.

A few bits of the bank also leave the block as decoded controls. These are the enables for five upper-memory shadow regions, a write-protect flag for those regions, and enables for the external and internal caches. The block also gives a one-cycle strobe each time a register that affects memory timing is written, so that downstream wait-state logic can re-evaluate.

Top module: `cfgport_top`

## Requirements
- R1: While reset is held and after it is released, the selector and every register read as 0x00, `shadow_en` is 0, `shadow_wp` is 0, `ext_cache_en` is 0, `int_cache_en` is 1 and `ws_update` is 0.
- R2: A write to address 0x00F2 stores the whole byte as the selector. A read at 0x00F2 returns the selector from the cycle after that write onward.
- R3: A write to address 0x00F3 stores data AND mask into the selected register, and masked-off bits read back as 0. The masks are: 0x01→0xD3, 0x02→0x7F, 0x03→0x1F, 0x05→0xF3, 0x06→0x1F, 0x07→0x1F, 0x08→0x0F, 0x09→0x03, 0x12→0xBB, 0x18→0x77, 0x19→0xFB, 0x1B→0xEF.
- R4: Registers 0x00, 0x04, 0x0A to 0x11 and 0x1A accept all eight bits.
- R5: A data write while the selector holds any other value (for example 0x13, 0x1C or 0x80) changes no register, and a read of that selector returns 0x00.
- R6: `shadow_en[4:0]` equals bits 4..0 of register 0x02, and `shadow_wp` equals bit 5 of register 0x02.
- R7: `ext_cache_en` equals bit 0 of register 0x04.
- R8: `int_cache_en` is the inverse of bit 6 of register 0x1A.
- R9: `ws_update` is high for exactly the one cycle after a data write to register 0x01, 0x04 or 0x1A, and low otherwise.
- R10: `io_rdata` is 0x00 unless `io_rd` is high at one of the two port addresses. Writes to any other address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational in the read cycle |
| shadow_en | output | 5 | Shadow region enables |
| shadow_wp | output | 1 | Shadow write protect |
| ext_cache_en | output | 1 | External cache enable |
| int_cache_en | output | 1 | Internal cache enable |
| ws_update | output | 1 | Timing-register write strobe |

## Verification
Read data is combinational, so the bench's monitor samples `io_rdata` on the falling edge inside the read cycle and compares it with the value the read task queued. A write takes effect at the rising edge that ends its cycle. The decoded controls and `ws_update` are therefore checked one time step after that edge, and the check that `ws_update` falls again is made one cycle later. Each read is issued in a cycle after the write it depends on has completed, so no comparison relies on the order of events at a clock edge.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

  localparam int BYTE_W = 8;

  typedef struct packed {
    logic                live;
    logic [BYTE_W-1:0]   mask;
  } wmask_t;

  // Writable-bit mask for each register number; live=0 means writes are dropped.
  function automatic wmask_t reg_wmask(input logic [BYTE_W-1:0] idx);
    wmask_t m;
    m.live = 1'b1;
    case (idx)
      8'h00, 8'h04, 8'h1A,
      8'h0A, 8'h0B, 8'h0C, 8'h0D,
      8'h0E, 8'h0F, 8'h10, 8'h11: m.mask = 8'hFF;
      8'h01:                      m.mask = 8'hD3;
      8'h02:                      m.mask = 8'h7F;
      8'h03, 8'h06, 8'h07:        m.mask = 8'h1F;
      8'h05:                      m.mask = 8'hF3;
      8'h08:                      m.mask = 8'h0F;
      8'h09:                      m.mask = 8'h03;
      8'h12:                      m.mask = 8'hBB;
      8'h18:                      m.mask = 8'h77;
      8'h19:                      m.mask = 8'hFB;
      8'h1B:                      m.mask = 8'hEF;
      default: begin
        m.live = 1'b0;
        m.mask = 8'h00;
      end
    endcase
    return m;
  endfunction

  // Registers whose writes must trigger a timing re-evaluation.
  function automatic logic is_timing_reg(input logic [BYTE_W-1:0] idx);
    return (idx == 8'h01) || (idx == 8'h04) || (idx == 8'h1A);
  endfunction

endpackage

// File: rtl/cfgport_decode.sv
module cfgport_decode #(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] IDX_PORT  = 16'h00F2,
  parameter logic [15:0] DATA_PORT = 16'h00F3
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic              idx_wr,
  output logic              data_wr,
  output logic              idx_rd,
  output logic              data_rd
);
  logic at_idx, at_data;

  assign at_idx  = (io_addr == IDX_PORT[ADDR_W-1:0]);
  assign at_data = (io_addr == DATA_PORT[ADDR_W-1:0]);

  assign idx_wr  = io_wr & at_idx;
  assign data_wr = io_wr & at_data;
  assign idx_rd  = io_rd & at_idx;
  assign data_rd = io_rd & at_data;
endmodule

// File: rtl/cfgport_bank.sv
module cfgport_bank
  import cfgport_pkg::*;
#(
  parameter int NUM_REGS = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             idx_wr,
  input  logic                             data_wr,
  input  logic [BYTE_W-1:0]                wdata,
  output logic [BYTE_W-1:0]                idx_q,
  output logic [NUM_REGS-1:0][BYTE_W-1:0]  bank_q,
  output logic [BYTE_W-1:0]                sel_byte
);
  localparam int IW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  always_ff @(posedge clk) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_wr) idx_q <= wdata;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam wmask_t WM = reg_wmask(BYTE_W'(g));
    if (WM.live) begin : g_live
      logic [BYTE_W-1:0] r_q;
      always_ff @(posedge clk) begin
        if (!rst_n)
          r_q <= '0;
        else if (data_wr && (idx_q == BYTE_W'(g)))
          r_q <= wdata & WM.mask;
      end
      assign bank_q[g] = r_q;
    end else begin : g_void
      assign bank_q[g] = '0;
    end
  end

  logic in_range;
  assign in_range = (int'(idx_q) < NUM_REGS);
  assign sel_byte = in_range ? bank_q[idx_q[IW-1:0]] : '0;
endmodule

// File: rtl/cfgport_ctl.sv
module cfgport_ctl
  import cfgport_pkg::*;
#(
  parameter int SHADOW_N = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_wr,
  input  logic [BYTE_W-1:0] idx_q,
  input  logic [BYTE_W-1:0] shadow_reg,
  input  logic [BYTE_W-1:0] cache_reg,
  input  logic [BYTE_W-1:0] icache_reg,
  output logic [SHADOW_N-1:0] shadow_en,
  output logic              shadow_wp,
  output logic              ext_cache_en,
  output logic              int_cache_en,
  output logic              ws_update
);
  assign shadow_en    = shadow_reg[SHADOW_N-1:0];
  assign shadow_wp    = shadow_reg[SHADOW_N];
  assign ext_cache_en = cache_reg[0];
  assign int_cache_en = ~icache_reg[6];

  always_ff @(posedge clk) begin
    if (!rst_n) ws_update <= 1'b0;
    else        ws_update <= data_wr & is_timing_reg(idx_q);
  end
endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
  import cfgport_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] IDX_PORT  = 16'h00F2,
  parameter logic [15:0] DATA_PORT = 16'h00F3,
  parameter int          NUM_REGS  = 32,
  parameter int          SHADOW_N  = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   io_addr,
  input  logic                io_wr,
  input  logic                io_rd,
  input  logic [7:0]          io_wdata,
  output logic [7:0]          io_rdata,
  output logic [SHADOW_N-1:0] shadow_en,
  output logic                shadow_wp,
  output logic                ext_cache_en,
  output logic                int_cache_en,
  output logic                ws_update
);
  localparam int SHADOW_REG = 8'h02;
  localparam int CACHE_REG  = 8'h04;
  localparam int ICACHE_REG = 8'h1A;

  logic idx_wr, data_wr, idx_rd, data_rd;
  logic [BYTE_W-1:0] idx_q, sel_byte;
  logic [NUM_REGS-1:0][BYTE_W-1:0] bank_q;

  cfgport_decode #(
    .ADDR_W(ADDR_W), .IDX_PORT(IDX_PORT), .DATA_PORT(DATA_PORT)
  ) u_dec (
    .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .idx_wr(idx_wr), .data_wr(data_wr), .idx_rd(idx_rd), .data_rd(data_rd)
  );

  cfgport_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .data_wr(data_wr),
    .wdata(io_wdata), .idx_q(idx_q), .bank_q(bank_q), .sel_byte(sel_byte)
  );

  cfgport_ctl #(.SHADOW_N(SHADOW_N)) u_ctl (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .idx_q(idx_q),
    .shadow_reg(bank_q[SHADOW_REG]), .cache_reg(bank_q[CACHE_REG]),
    .icache_reg(bank_q[ICACHE_REG]),
    .shadow_en(shadow_en), .shadow_wp(shadow_wp),
    .ext_cache_en(ext_cache_en), .int_cache_en(int_cache_en),
    .ws_update(ws_update)
  );

  always_comb begin
    if (idx_rd)       io_rdata = idx_q;
    else if (data_rd) io_rdata = sel_byte;
    else              io_rdata = '0;
  end
endmodule

// File: rtl/cfgport_chk.sv
module cfgport_chk
  import cfgport_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int SHADOW_N = 5
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          idx_wr,
  input logic                          data_wr,
  input logic [7:0]                    wdata,
  input logic [7:0]                    idx_q,
  input logic [NUM_REGS*8-1:0]         bank_flat,
  input logic [SHADOW_N-1:0]           shadow_en,
  input logic                          shadow_wp,
  input logic                          ext_cache_en,
  input logic                          int_cache_en,
  input logic                          ws_update
);
  logic dead_wr, shadow_wr, cache_wr, icache_wr, timing_wr;
  assign dead_wr   = data_wr && !reg_wmask(idx_q).live;
  assign shadow_wr = data_wr && (idx_q == 8'h02);
  assign cache_wr  = data_wr && (idx_q == 8'h04);
  assign icache_wr = data_wr && (idx_q == 8'h1A);
  assign timing_wr = data_wr && is_timing_reg(idx_q);

  // R2
  idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> (idx_q == $past(wdata)));
  // R5
  dead_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dead_wr |=> $stable(bank_flat));
  // R6
  shadow_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_wr |=> (shadow_en == $past(wdata[SHADOW_N-1:0])) && (shadow_wp == $past(wdata[SHADOW_N])));
  // R7
  ext_cache_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cache_wr |=> (ext_cache_en == $past(wdata[0])));
  // R8
  int_cache_chk: assert property (@(posedge clk) disable iff (!rst_n)
    icache_wr |=> (int_cache_en != $past(wdata[6])));
  // R9
  ws_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timing_wr |=> ws_update);
  // R9
  ws_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ws_update |-> $past(timing_wr));
endmodule

bind cfgport_top cfgport_chk #(.NUM_REGS(NUM_REGS), .SHADOW_N(SHADOW_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .data_wr(data_wr),
  .wdata(io_wdata), .idx_q(idx_q), .bank_flat(bank_q),
  .shadow_en(shadow_en), .shadow_wp(shadow_wp),
  .ext_cache_en(ext_cache_en), .int_cache_en(int_cache_en),
  .ws_update(ws_update)
);

// File: tb/test_cfgport_top.sv
module test_cfgport_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic [4:0]  shadow_en;
  logic        shadow_wp, ext_cache_en, int_cache_en, ws_update;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  cfgport_top i_cfgport_top (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .shadow_en(shadow_en),
    .shadow_wp(shadow_wp), .ext_cache_en(ext_cache_en),
    .int_cache_en(int_cache_en), .ws_update(ws_update)
  );

  // Bench's own view of the writable bits per register number.
  function automatic logic [7:0] model_mask(input int r);
    if (r == 0 || r == 4 || r == 26 || (r >= 10 && r <= 17)) return 8'hFF;
    if (r == 3 || r == 6 || r == 7) return 8'h1F;
    if (r == 1)  return 8'hD3;
    if (r == 2)  return 8'h7F;
    if (r == 5)  return 8'hF3;
    if (r == 8)  return 8'h0F;
    if (r == 9)  return 8'h03;
    if (r == 18) return 8'hBB;
    if (r == 24) return 8'h77;
    if (r == 25) return 8'hFB;
    if (r == 27) return 8'hEF;
    return 8'h00;
  endfunction

  task automatic check_eq(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(posedge clk); #1;
    io_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    io_addr = a; io_rd = 1'b1;
    @(posedge clk); #1;
    io_rd = 1'b0;
  endtask

  // Monitor: compare read data mid-cycle against the queued expectation.
  always @(negedge clk) begin
    if (io_rd) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10: actual=%h expected=<no read queued>", io_rdata);
      end else begin
        string t;
        logic [7:0] e;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        check_eq(t, io_rdata, e);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 during reset
    check_eq("R1 ws", {7'b0, ws_update}, 8'h00);
    check_eq("R1 int", {7'b0, int_cache_en}, 8'h01);
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 after reset
    check_eq("R1 shadow", {2'b0, shadow_wp, shadow_en}, 8'h00);
    check_eq("R1 ext", {7'b0, ext_cache_en}, 8'h00);
    check_eq("R1 int", {7'b0, int_cache_en}, 8'h01);
    bus_rd(16'h00F2, 8'h00, "R1 idx");
    bus_rd(16'h00F3, 8'h00, "R1 reg0");

    // R2 selector readback
    bus_wr(16'h00F2, 8'h3C);
    bus_rd(16'h00F2, 8'h3C, "R2 idx");
    bus_wr(16'h00F2, 8'hC5);
    bus_rd(16'h00F2, 8'hC5, "R2 idx");

    // R3 R4 R5 sweep with all ones then a pattern
    for (int r = 0; r < 32; r++) begin
      bus_wr(16'h00F2, 8'(r));
      bus_wr(16'h00F3, 8'hFF);
      bus_rd(16'h00F3, model_mask(r), (model_mask(r) == 8'hFF) ? "R4 full" :
                                      (model_mask(r) == 8'h00) ? "R5 ignored" : "R3 masked");
    end
    for (int r = 0; r < 32; r++) begin
      bus_wr(16'h00F2, 8'(r));
      bus_wr(16'h00F3, 8'hA5);
      bus_rd(16'h00F3, 8'hA5 & model_mask(r), "R3 pattern");
    end

    // R5 out-of-range selector, neighbours unchanged
    bus_wr(16'h00F2, 8'h80);
    bus_wr(16'h00F3, 8'h77);
    bus_rd(16'h00F3, 8'h00, "R5 idx80");
    bus_wr(16'h00F2, 8'h1B);
    bus_rd(16'h00F3, 8'hA5 & 8'hEF, "R5 neighbour");

    // R10 foreign address and idle read
    bus_wr(16'h00F4, 8'h11);
    bus_rd(16'h00F2, 8'h1B, "R10 foreign wr");
    bus_rd(16'h00F1, 8'h00, "R10 foreign rd");
    #0 check_eq("R10 idle", io_rdata, 8'h00);

    // R6 shadow decode
    bus_wr(16'h00F2, 8'h02);
    bus_wr(16'h00F3, 8'hFF);
    check_eq("R6 all", {2'b0, shadow_wp, shadow_en}, 8'h3F);
    bus_wr(16'h00F3, 8'h15);
    check_eq("R6 pat", {2'b0, shadow_wp, shadow_en}, 8'h15);
    check_eq("R9 no strobe", {7'b0, ws_update}, 8'h00);

    // R7 + R9
    bus_wr(16'h00F2, 8'h04);
    bus_wr(16'h00F3, 8'h00);
    check_eq("R7 off", {7'b0, ext_cache_en}, 8'h00);
    bus_wr(16'h00F3, 8'h01);
    check_eq("R7 on", {7'b0, ext_cache_en}, 8'h01);
    check_eq("R9 strobe", {7'b0, ws_update}, 8'h01);
    @(posedge clk); #1;
    check_eq("R9 one cycle", {7'b0, ws_update}, 8'h00);

    // R8 + R9
    bus_wr(16'h00F2, 8'h1A);
    bus_wr(16'h00F3, 8'h40);
    check_eq("R8 off", {7'b0, int_cache_en}, 8'h00);
    check_eq("R9 strobe", {7'b0, ws_update}, 8'h01);
    bus_wr(16'h00F3, 8'hBF);
    check_eq("R8 on", {7'b0, int_cache_en}, 8'h01);

    // R9 register 0x01 and a non-timing register
    bus_wr(16'h00F2, 8'h01);
    check_eq("R9 idx write", {7'b0, ws_update}, 8'h00);
    bus_wr(16'h00F3, 8'h00);
    check_eq("R9 reg01", {7'b0, ws_update}, 8'h01);
    bus_wr(16'h00F2, 8'h03);
    bus_wr(16'h00F3, 8'h00);
    check_eq("R9 reg03", {7'b0, ws_update}, 8'h00);

    @(posedge clk); #1;
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule